// File: doc/BRIEF.md
# Acquisition Engine Control Register File

This block is the processor-facing control and status front end of a correlation-based signal acquisition engine. Software reaches it through a small word-addressed register bus with sixteen 32-bit locations and separate read and write strobes. Through it software sets the engine's configuration: input queue, total vector length, unpadded sample count and log2 of the transform length. It also gates incoming samples, checks that the hardware is present through a loopback register, and issues launch and reset commands.

The reference code that the correlator compares against is streamed in through a single data location. Each write to it is forwarded to the engine's code memory at an internal address that steps up by one per write. A dedicated key word written to a second location rewinds that address. Several addresses mean one thing on write and another on read: a read returns the engine's results (peak index, peak magnitude, power sum, Doppler index and a 64-bit initial sample count). The engine reports completion with a done strobe, which this block turns into a level interrupt for software.

Top module: `acq_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset clears every configuration output, the sample-block flag, the test register, the code address counter, the interrupt and all pulse outputs to zero.
- R2: Address 15 is a loopback register: any 32-bit value written there (0x55AA among them) is returned by a later read of address 15. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R3: Writes to address 0 (queue select), 1 (vector length), 2 (unpadded sample count) and 7 (log2 transform length) show on their configuration outputs in the cycle after the write. Addresses 0 and 7 read back their stored values.
- R4: Bit 0 of a write to address 14 sets `samples_block` (1 blocks, 0 unblocks) and the other bits are ignored. A read of address 14 returns the flag in bit 0 with zeros above it.
- R5: Writing the value 1 to address 8 gives a one-cycle `eng_launch` pulse in the cycle after the write. Writing 2 gives a one-cycle `eng_reset` pulse. Any other value gives neither pulse. Addresses 8 and 9 read as zero.
- R6: Each accepted write to address 6 gives a one-cycle `code_we` in the next cycle, with `code_addr` equal to the counter value before the write, `code_re` equal to data bits 15:0 and `code_im` equal to bits 31:16. The counter then increments by one.
- R7: Writing exactly 0x10000000 to address 9 sets the code address counter to 0. Any other value written there leaves the counter unchanged.
- R8: When the counter equals the configured vector length, or the code memory depth, a write to address 6 is ignored: no `code_we` pulse occurs and the counter does not advance.
- R9: On read, address 1 returns bits 31:0 of the initial sample count and address 2 returns bits 63:32. Address 3 returns the peak index, address 4 the power sum, address 5 the Doppler index and address 6 the peak magnitude.
- R10: `irq` rises in the cycle after `eng_done` is high. It stays high until a launch or reset command is written to address 8, and goes low in the cycle after that write. If the command and `eng_done` arrive in the same cycle, the command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| eng_done | input | 1 | Engine completion strobe |
| res_init_sample | input | 64 | Initial sample count result |
| res_peak_idx | input | 32 | Peak index result |
| res_power | input | 32 | Power sum result |
| res_doppler_idx | input | 32 | Doppler index result |
| res_peak_mag | input | 32 | Peak magnitude result |
| cfg_queue | output | 32 | Input queue select |
| cfg_vec_len | output | 32 | Total vector length |
| cfg_nsamp | output | 32 | Samples excluding padding |
| cfg_fft_log2 | output | 32 | log2 of transform length |
| samples_block | output | 1 | Sample blocking flag |
| eng_launch | output | 1 | Launch pulse |
| eng_reset | output | 1 | Engine reset pulse |
| irq | output | 1 | Completion interrupt level |
| code_we | output | 1 | Code memory write enable |
| code_addr | output | CODE_AW | Code memory address |
| code_re | output | 16 | Code word real part |
| code_im | output | 16 | Code word imaginary part |

## Verification
The assertions check on every cycle the interrupt's set, hold and clear rules and the mutual exclusion of the two command pulses. They also check that every code write lands below the vector length in force, that a saturated write leaves the counter alone, that the rewind key zeroes the counter, and that read data holds still without a read strobe. Only the bench's scenarios can show the read/write split at addresses 1 and 2. The same applies to the exact data and address carried by each code write, to a wrong rewind key being ignored, and to the full reset state, since these need specific write-then-read sequences compared against expected values.

// File: rtl/acq_ctrl_pkg.sv
package acq_ctrl_pkg;

    localparam int WORD_W = 32;
    localparam int BUS_AW = 4;

    localparam logic [BUS_AW-1:0] RA_QUEUE   = 4'd0;
    localparam logic [BUS_AW-1:0] RA_VLEN    = 4'd1;
    localparam logic [BUS_AW-1:0] RA_NSAMP   = 4'd2;
    localparam logic [BUS_AW-1:0] RA_PEAKIX  = 4'd3;
    localparam logic [BUS_AW-1:0] RA_POWER   = 4'd4;
    localparam logic [BUS_AW-1:0] RA_DOPPLER = 4'd5;
    localparam logic [BUS_AW-1:0] RA_CODE    = 4'd6;
    localparam logic [BUS_AW-1:0] RA_FFTLOG  = 4'd7;
    localparam logic [BUS_AW-1:0] RA_CMD     = 4'd8;
    localparam logic [BUS_AW-1:0] RA_CODECLR = 4'd9;
    localparam logic [BUS_AW-1:0] RA_BLOCK   = 4'd14;
    localparam logic [BUS_AW-1:0] RA_TEST    = 4'd15;

    localparam logic [WORD_W-1:0] CMD_LAUNCH   = 32'd1;
    localparam logic [WORD_W-1:0] CMD_RESET    = 32'd2;
    localparam logic [WORD_W-1:0] CODE_CLR_KEY = 32'h1000_0000;

    typedef struct packed {
        logic [WORD_W-1:0] queue;
        logic [WORD_W-1:0] vec_len;
        logic [WORD_W-1:0] nsamp;
        logic [WORD_W-1:0] fft_log2;
    } cfg_t;

    typedef struct packed {
        logic [63:0]       init_sample;
        logic [WORD_W-1:0] peak_idx;
        logic [WORD_W-1:0] power;
        logic [WORD_W-1:0] doppler_idx;
        logic [WORD_W-1:0] peak_mag;
    } result_t;

    typedef struct packed {
        logic [15:0] im;
        logic [15:0] re;
    } code_word_t;

    function automatic code_word_t split_code(input logic [WORD_W-1:0] w);
        code_word_t c;
        c.re = w[15:0];
        c.im = w[31:16];
        return c;
    endfunction

endpackage

// File: rtl/acq_code_loader.sv
module acq_code_loader
    import acq_ctrl_pkg::*;
#(
    parameter int CODE_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_code,
    input  logic               clr_req,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [WORD_W-1:0]  vec_len,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [15:0]        code_re,
    output logic [15:0]        code_im
);
    localparam int CNT_W = CODE_AW + 1;
    localparam int DEPTH = 1 << CODE_AW;

    logic [CNT_W-1:0] cnt;
    logic             at_end;
    logic             accept;
    code_word_t       word;

    assign word   = split_code(wdata);
    assign at_end = (WORD_W'(cnt) >= vec_len) || (cnt == CNT_W'(DEPTH));
    assign accept = wr_code && !at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            code_we   <= 1'b0;
            code_addr <= '0;
            code_re   <= '0;
            code_im   <= '0;
        end else begin
            code_we <= accept;
            if (accept) begin
                code_addr <= cnt[CODE_AW-1:0];
                code_re   <= word.re;
                code_im   <= word.im;
            end
            if (clr_req)
                cnt <= '0;
            else if (accept)
                cnt <= cnt + 1'b1;
        end
    end

    // R7: the rewind key zeroes the counter
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (cnt == '0));

    // R8: every forwarded write lies below the vector length in force
    p_bound_r8: assert property (@(posedge clk) disable iff (rst)
        code_we |-> (WORD_W'(code_addr) < $past(vec_len)));

    // R8: a write at the limit neither pulses nor advances
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_code && at_end && !clr_req) |=> (!code_we && cnt == $past(cnt)));

endmodule

// File: rtl/acq_cmd_irq.sv
module acq_cmd_irq
    import acq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              eng_done,
    output logic              eng_launch,
    output logic              eng_reset,
    output logic              irq
);
    logic is_launch, is_reset, clr;

    assign is_launch = cmd_wr && (wdata == CMD_LAUNCH);
    assign is_reset  = cmd_wr && (wdata == CMD_RESET);
    assign clr       = is_launch || is_reset;

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_launch <= 1'b0;
            eng_reset  <= 1'b0;
            irq        <= 1'b0;
        end else begin
            eng_launch <= is_launch;
            eng_reset  <= is_reset;
            if (clr)
                irq <= 1'b0;
            else if (eng_done)
                irq <= 1'b1;
        end
    end

    // R5: the two command pulses never coincide
    p_cmd_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(eng_launch && eng_reset));

    // R10: done without a command raises the interrupt
    p_irq_set_r10: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !clr) |=> irq);

    // R10: the interrupt holds until a command
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

    // R10: a command clears it, winning over done
    p_irq_clr_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!irq && (eng_launch || eng_reset)));

endmodule

// File: rtl/acq_rd_mux.sv
module acq_rd_mux
    import acq_ctrl_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    input  cfg_t              cfg,
    input  result_t           res,
    input  logic              block,
    input  logic [WORD_W-1:0] test,
    output logic [WORD_W-1:0] data
);
    always_comb begin
        case (addr)
            RA_QUEUE:   data = cfg.queue;
            RA_VLEN:    data = res.init_sample[31:0];
            RA_NSAMP:   data = res.init_sample[63:32];
            RA_PEAKIX:  data = res.peak_idx;
            RA_POWER:   data = res.power;
            RA_DOPPLER: data = res.doppler_idx;
            RA_CODE:    data = res.peak_mag;
            RA_FFTLOG:  data = cfg.fft_log2;
            RA_BLOCK:   data = {{(WORD_W-1){1'b0}}, block};
            RA_TEST:    data = test;
            default:    data = '0;
        endcase
    end
endmodule

// File: rtl/acq_ctrl_regs.sv
module acq_ctrl_regs
    import acq_ctrl_pkg::*;
#(
    parameter int CODE_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [31:0]        bus_rdata,
    input  logic               eng_done,
    input  logic [63:0]        res_init_sample,
    input  logic [31:0]        res_peak_idx,
    input  logic [31:0]        res_power,
    input  logic [31:0]        res_doppler_idx,
    input  logic [31:0]        res_peak_mag,
    output logic [31:0]        cfg_queue,
    output logic [31:0]        cfg_vec_len,
    output logic [31:0]        cfg_nsamp,
    output logic [31:0]        cfg_fft_log2,
    output logic               samples_block,
    output logic               eng_launch,
    output logic               eng_reset,
    output logic               irq,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [15:0]        code_re,
    output logic [15:0]        code_im
);
    cfg_t              cfg_q;
    result_t           res;
    logic              block_q;
    logic [WORD_W-1:0] test_q;
    logic [WORD_W-1:0] rd_data;

    logic wr_at_code, wr_at_clr, wr_at_cmd;

    assign wr_at_code = bus_wr && (bus_addr == RA_CODE);
    assign wr_at_clr  = bus_wr && (bus_addr == RA_CODECLR) && (bus_wdata == CODE_CLR_KEY);
    assign wr_at_cmd  = bus_wr && (bus_addr == RA_CMD);

    assign res = '{init_sample: res_init_sample, peak_idx: res_peak_idx,
                   power: res_power, doppler_idx: res_doppler_idx,
                   peak_mag: res_peak_mag};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            block_q   <= 1'b0;
            test_q    <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    RA_QUEUE:  cfg_q.queue    <= bus_wdata;
                    RA_VLEN:   cfg_q.vec_len  <= bus_wdata;
                    RA_NSAMP:  cfg_q.nsamp    <= bus_wdata;
                    RA_FFTLOG: cfg_q.fft_log2 <= bus_wdata;
                    RA_BLOCK:  block_q        <= bus_wdata[0];
                    RA_TEST:   test_q         <= bus_wdata;
                    default: ;
                endcase
            end
            if (bus_rd)
                bus_rdata <= rd_data;
        end
    end

    assign cfg_queue     = cfg_q.queue;
    assign cfg_vec_len   = cfg_q.vec_len;
    assign cfg_nsamp     = cfg_q.nsamp;
    assign cfg_fft_log2  = cfg_q.fft_log2;
    assign samples_block = block_q;

    acq_rd_mux u_rd_mux (
        .addr  (bus_addr),
        .cfg   (cfg_q),
        .res   (res),
        .block (block_q),
        .test  (test_q),
        .data  (rd_data)
    );

    acq_code_loader #(.CODE_AW(CODE_AW)) u_code_loader (
        .clk       (clk),
        .rst       (rst),
        .wr_code   (wr_at_code),
        .clr_req   (wr_at_clr),
        .wdata     (bus_wdata),
        .vec_len   (cfg_q.vec_len),
        .code_we   (code_we),
        .code_addr (code_addr),
        .code_re   (code_re),
        .code_im   (code_im)
    );

    acq_cmd_irq u_cmd_irq (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (wr_at_cmd),
        .wdata      (bus_wdata),
        .eng_done   (eng_done),
        .eng_launch (eng_launch),
        .eng_reset  (eng_reset),
        .irq        (irq)
    );

    // R2: read data changes only on a read strobe
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R3: a vector length write reaches its output next cycle
    p_vlen_wr_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_VLEN) |=> (cfg_vec_len == $past(bus_wdata)));

    // R4: the blocking flag follows bit 0 only
    p_block_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_BLOCK) |=> (samples_block == $past(bus_wdata[0])));

endmodule

// File: tb/acq_ctrl_regs_bench.sv
module acq_ctrl_regs_bench;
    localparam int CODE_AW = 10;
    localparam logic [63:0] RES_INIT = 64'h0000_0007_89AB_CDEF;
    localparam logic [31:0] RES_PIX  = 32'h0000_0123;
    localparam logic [31:0] RES_PWR  = 32'h00AB_0000;
    localparam logic [31:0] RES_DOP  = 32'h0000_0011;
    localparam logic [31:0] RES_MAG  = 32'h0F0F_1234;

    // {addr, write data, expected read}
    localparam int NV = 8;
    localparam logic [67:0] VEC [NV] = '{
        {4'd15, 32'h0000_55AA, 32'h0000_55AA},
        {4'd15, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {4'd0,  32'h0000_0003, 32'h0000_0003},
        {4'd7,  32'h0000_000C, 32'h0000_000C},
        {4'd14, 32'hFFFF_FFFE, 32'h0000_0000},
        {4'd14, 32'h0000_0003, 32'h0000_0001},
        {4'd1,  32'h0000_0400, 32'h89AB_CDEF},
        {4'd2,  32'h0000_0300, 32'h0000_0007}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, eng_done = 1'b0;
    logic [31:0] bus_rdata, cfg_queue, cfg_vec_len, cfg_nsamp, cfg_fft_log2;
    logic samples_block, eng_launch, eng_reset, irq, code_we;
    logic [CODE_AW-1:0] code_addr;
    logic [15:0] code_re, code_im;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    acq_ctrl_regs #(.CODE_AW(CODE_AW)) u_acq_ctrl_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .res_init_sample(RES_INIT),
        .res_peak_idx(RES_PIX), .res_power(RES_PWR),
        .res_doppler_idx(RES_DOP), .res_peak_mag(RES_MAG),
        .cfg_queue(cfg_queue), .cfg_vec_len(cfg_vec_len), .cfg_nsamp(cfg_nsamp),
        .cfg_fft_log2(cfg_fft_log2), .samples_block(samples_block),
        .eng_launch(eng_launch), .eng_reset(eng_reset), .irq(irq),
        .code_we(code_we), .code_addr(code_addr), .code_re(code_re), .code_im(code_im)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_reset_state(input string tag);
        logic [31:0] t;
        chk(tag, {cfg_queue, cfg_vec_len}, 64'd0);
        chk(tag, {cfg_nsamp, cfg_fft_log2}, 64'd0);
        chk(tag, {60'd0, samples_block, irq, eng_launch, eng_reset}, 64'd0);
        chk(tag, {63'd0, code_we}, 64'd0);
        rd(4'd15, t);
        chk(tag, {32'd0, t}, 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state straight after reset
        check_reset_state("R1 initial");

        // table walk: R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            rd(VEC[i][67:64], d);
            chk($sformatf("table(R2 R3 R4 R9) entry %0d", i), {32'd0, d}, {32'd0, VEC[i][31:0]});
        end
        chk("R3 queue out", {32'd0, cfg_queue}, 64'd3);
        chk("R3 fft log2 out", {32'd0, cfg_fft_log2}, 64'hC);
        chk("R3 vec len out", {32'd0, cfg_vec_len}, 64'h400);
        chk("R3 nsamp out", {32'd0, cfg_nsamp}, 64'h300);
        chk("R4 block out", {63'd0, samples_block}, 64'd1);
        wr(4'd14, 32'h0000_0000);
        chk("R4 unblock", {63'd0, samples_block}, 64'd0);

        // R9 remaining result addresses
        rd(4'd3, d); chk("R9 peak idx", {32'd0, d}, {32'd0, RES_PIX});
        rd(4'd4, d); chk("R9 power", {32'd0, d}, {32'd0, RES_PWR});
        rd(4'd5, d); chk("R9 doppler", {32'd0, d}, {32'd0, RES_DOP});
        rd(4'd6, d); chk("R9 magnitude", {32'd0, d}, {32'd0, RES_MAG});
        rd(4'd8, d); chk("R5 cmd reads zero", {32'd0, d}, 64'd0);

        // R5 command pulses
        wr(4'd8, 32'd1);
        chk("R5 launch pulse", {62'd0, eng_launch, eng_reset}, 64'b10);
        @(negedge clk);
        chk("R5 launch one cycle", {62'd0, eng_launch, eng_reset}, 64'b00);
        wr(4'd8, 32'd2);
        chk("R5 reset pulse", {62'd0, eng_launch, eng_reset}, 64'b01);
        wr(4'd8, 32'd3);
        chk("R5 other value no pulse", {62'd0, eng_launch, eng_reset}, 64'b00);

        // R6 code loading
        wr(4'd1, 32'd3);
        wr(4'd9, 32'h1000_0000);
        wr(4'd6, 32'hBEEF_1234);
        chk("R6 first we", {63'd0, code_we}, 64'd1);
        chk("R6 first addr/re/im", {22'd0, code_addr, code_im, code_re},
            {22'd0, 10'd0, 16'hBEEF, 16'h1234});
        @(negedge clk);
        chk("R6 we one cycle", {63'd0, code_we}, 64'd0);
        wr(4'd6, 32'h0002_0001);
        chk("R6 second addr", {22'd0, code_addr, code_im, code_re},
            {22'd0, 10'd1, 16'h0002, 16'h0001});
        wr(4'd6, 32'h0004_0003);
        chk("R6 third addr", {54'd0, code_addr}, 64'd2);
        // R8 saturation at vector length 3
        wr(4'd6, 32'h0006_0005);
        chk("R8 write beyond length ignored", {63'd0, code_we}, 64'd0);
        // R7 wrong key leaves counter saturated
        wr(4'd9, 32'h1000_0001);
        wr(4'd6, 32'h0008_0007);
        chk("R7 wrong key no rewind", {63'd0, code_we}, 64'd0);
        wr(4'd9, 32'h1000_0000);
        wr(4'd6, 32'h000A_0009);
        chk("R7 rewind then write", {53'd0, code_we, code_addr}, {53'd0, 1'b1, 10'd0});
        // R8 raising the length lets loading resume from the held count
        wr(4'd1, 32'd5);
        wr(4'd6, 32'h000C_000B);
        chk("R8 resume after length raise", {53'd0, code_we, code_addr}, {53'd0, 1'b1, 10'd1});

        // R10 interrupt
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        chk("R10 irq set", {63'd0, irq}, 64'd1);
        repeat (4) @(negedge clk);
        chk("R10 irq held", {63'd0, irq}, 64'd1);
        wr(4'd8, 32'd7);
        chk("R10 irq held on non-command", {63'd0, irq}, 64'd1);
        wr(4'd8, 32'd1);
        chk("R10 irq cleared by launch", {63'd0, irq}, 64'd0);
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        chk("R10 irq set again", {63'd0, irq}, 64'd1);
        @(negedge clk);
        eng_done = 1'b1; bus_addr = 4'd8; bus_wdata = 32'd2; bus_wr = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; bus_wr = 1'b0;
        chk("R10 command wins over done", {62'd0, irq, eng_reset}, 64'b01);

        // R1 reset after activity
        wr(4'd0, 32'h55);
        wr(4'd14, 32'd1);
        wr(4'd15, 32'h0000_55AA);
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1 after use");
        wr(4'd1, 32'd4);
        wr(4'd6, 32'h1111_2222);
        chk("R1 counter cleared by reset", {53'd0, code_we, code_addr}, {53'd0, 1'b1, 10'd0});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule